// File: doc/BRIEF.md
# Debug Port Protocol Select Watcher

This block sits on the target side of a shared debug data pin and decides whether the debug port obeys the JTAG protocol or the two-wire serial debug protocol. It samples that single pin on each rising edge of the debug clock. It counts runs of consecutive ones to spot a line reset. It then looks for one fixed 16-bit selection pattern, which has to follow such a reset run with no gap.

Out of reset the port is in JTAG mode. The mode flag switches to serial-wire mode only when a complete and correct selection pattern arrives right after a run of at least 50 ones. The flag then stays set until the next reset. Whenever a run of ones reaches 50, the block also gives a one-cycle line-reset pulse, in either mode, for the serial-wire port logic that follows it. The TAP controller and the packet engine are not part of this block.

Top module: `dbg_proto_watch`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `swd_sel_o` is 0 (JTAG mode) and `line_rst_o` is 0.
- R2: `line_rst_o` goes high for exactly one cycle. It is high in the cycle that follows the sampling edge of the 50th consecutive 1. A run of only 49 ones gives no pulse.
- R3: Ones beyond the 50th give no further pulse. Any sampled 0 restarts the count, so a later run needs 50 fresh ones to pulse again.
- R4: The line-reset pulse is produced in serial-wire mode just as it is in JTAG mode.
- R5: Take a run of 50 or more ones, followed at once by the 16 wire bits 0,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1. Written as a word with the first wire bit in bit 0, this is 16'hE79E. This stream sets `swd_sel_o` to 1 in the cycle after the 16th bit is sampled. The first 0 of the pattern is the bit that ends the run.
- R6: The correct 16-bit pattern has no effect if the run of ones before it is shorter than 50.
- R7: If the 16 bits after a reset run differ from the pattern in any position, the mode is left as it was and the watcher returns to hunting for a reset run. Ones at the end of a rejected window count toward the next run.
- R8: Once `swd_sel_o` is 1, it stays 1 until `rst`, whatever bits arrive on the pin, including rejected windows.
- R9: A synchronous `rst` in the middle of a stream returns the block to JTAG mode and clears the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the pin is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_line_i | input | 1 | Shared debug data / mode-select pin value |
| swd_sel_o | output | 1 | 1 = serial-wire mode selected, 0 = JTAG mode |
| line_rst_o | output | 1 | One-cycle pulse when a run of ones reaches 50 |

## Verification
The run counter and the pattern window run side by side. While a 16-bit window is being judged, the same bits keep feeding the run count. The bench provokes this with a window whose first bit is 0 and whose other 15 bits are 1, which is rejected, and then sends 35 more ones. The pulse must come on the 35th one, because 15 + 35 = 50. A zero followed by the true pattern must then be accepted, because the run that ended the rejected window is already a valid reset run. The checker compares the pulse with its own count of consecutive ones. At every rise of the mode flag it also compares its own history of the last 16 bits with the pattern.

// File: rtl/dbg_proto_watch_pkg.sv
package dbg_proto_watch_pkg;

  // Window tracker state: waiting for a reset run, or collecting a window.
  typedef enum logic {
    WS_HUNT    = 1'b0,
    WS_COLLECT = 1'b1
  } watch_state_e;

  // Default selection word, first wire bit in bit 0.
  localparam logic [15:0] SEL_CODE_DEF = 16'hE79E;
  localparam int          RUN_LEN_DEF  = 50;
  localparam int          CNT_W_DEF    = 6;

endpackage

// File: rtl/dbg_proto_watch_run.sv
module dbg_proto_watch_run #(
  parameter int RUN_LEN = 50,
  parameter int CNT_W   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic run_met_o,
  output logic hit_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= din && (cnt_q == CNT_PRE);
      if (!din) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_met_o = (cnt_q >= CNT_HIT);

endmodule

// File: rtl/dbg_proto_watch_match.sv
module dbg_proto_watch_match
  import dbg_proto_watch_pkg::*;
#(
  parameter int               SEL_W    = 16,
  parameter logic [SEL_W-1:0] SEL_CODE = SEL_CODE_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic arm_i,
  output logic ok_o
);

  localparam int               IDX_W    = $clog2(SEL_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEL_W - 1);

  watch_state_e     state_q;
  logic [SEL_W-1:0] shreg_q;
  logic [SEL_W-1:0] shreg_nx;
  logic [IDX_W-1:0] idx_q;
  logic             last_bit;

  // The newest bit enters at the top; the earliest ends up in bit 0.
  assign shreg_nx = {din, shreg_q[SEL_W-1:1]};
  assign last_bit = (state_q == WS_COLLECT) && (idx_q == LAST_IDX);
  assign ok_o     = last_bit && (shreg_nx == SEL_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_HUNT;
      shreg_q <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        WS_HUNT: begin
          if (arm_i) begin
            state_q <= WS_COLLECT;
            shreg_q <= shreg_nx;
            idx_q   <= IDX_W'(1);
          end
        end
        WS_COLLECT: begin
          shreg_q <= shreg_nx;
          if (last_bit) begin
            state_q <= WS_HUNT;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= WS_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/dbg_proto_watch.sv
module dbg_proto_watch
  import dbg_proto_watch_pkg::*;
#(
  parameter int               RUN_LEN  = RUN_LEN_DEF,
  parameter int               CNT_W    = CNT_W_DEF,
  parameter int               SEL_W    = 16,
  parameter logic [SEL_W-1:0] SEL_CODE = SEL_CODE_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic dbg_line_i,
  output logic swd_sel_o,
  output logic line_rst_o
);

  logic run_met;
  logic sel_ok;
  logic arm;
  logic mode_q;

  dbg_proto_watch_run #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) u_run (
    .clk       (clk),
    .rst       (rst),
    .din       (dbg_line_i),
    .run_met_o (run_met),
    .hit_o     (line_rst_o)
  );

  // A zero that ends a long enough run is the first bit of a window.
  assign arm = run_met && !dbg_line_i;

  dbg_proto_watch_match #(
    .SEL_W    (SEL_W),
    .SEL_CODE (SEL_CODE)
  ) u_match (
    .clk   (clk),
    .rst   (rst),
    .din   (dbg_line_i),
    .arm_i (arm),
    .ok_o  (sel_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
    end else if (sel_ok) begin
      mode_q <= 1'b1;
    end
  end

  assign swd_sel_o = mode_q;

endmodule

// File: rtl/dbg_proto_watch_chk.sv
module dbg_proto_watch_chk #(
  parameter int          RUN_LEN  = 50,
  parameter int          SEL_W    = 16,
  parameter logic [SEL_W-1:0] SEL_CODE = 16'hE79E
) (
  input logic clk,
  input logic rst,
  input logic dbg_line_i,
  input logic swd_sel_o,
  input logic line_rst_o
);

  int unsigned      chk_run;
  logic [SEL_W-1:0] chk_hist;
  logic             past_rst = 1'b0;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst) begin
      chk_run  <= 0;
      chk_hist <= '0;
    end else begin
      chk_hist <= {dbg_line_i, chk_hist[SEL_W-1:1]};
      if (!dbg_line_i) chk_run <= 0;
      else if (chk_run <= RUN_LEN) chk_run <= chk_run + 1;
    end
  end

  // R1: idle outputs in the cycle after reset
  always_ff @(posedge clk) begin
    if (past_rst) begin
      p_reset_idle_r1: assert (!swd_sel_o && !line_rst_o)
        else $error("reset state violated");
    end
  end

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    line_rst_o |=> !line_rst_o);

  p_pulse_at_run_r3: assert property (@(posedge clk) disable iff (rst)
    line_rst_o == (chk_run == RUN_LEN));

  p_mode_rise_pattern_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(swd_sel_o) |-> (chk_hist == SEL_CODE));

  p_mode_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    swd_sel_o |=> swd_sel_o);

endmodule

bind dbg_proto_watch dbg_proto_watch_chk #(
  .RUN_LEN  (RUN_LEN),
  .SEL_W    (SEL_W),
  .SEL_CODE (SEL_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dbg_line_i (dbg_line_i),
  .swd_sel_o  (swd_sel_o),
  .line_rst_o (line_rst_o)
);

// File: tb/test_dbg_proto_watch.sv
module test_dbg_proto_watch;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 14;

  // Row layout: [32:29] requirement, [28] reset first, [27:20] ones,
  // [19] send window, [18:3] window (bit 0 first), [2] mode after, [1:0] pulses.
  localparam logic [32:0] VECS [NVEC] = '{
    {4'd2, 1'b1, 8'd49, 1'b0, 16'h0000, 1'b0, 2'd0}, // R2 49 ones: no pulse
    {4'd2, 1'b1, 8'd50, 1'b0, 16'h0000, 1'b0, 2'd1}, // R2 50 ones: one pulse
    {4'd3, 1'b1, 8'd80, 1'b0, 16'h0000, 1'b0, 2'd1}, // R3 long run: still one
    {4'd5, 1'b1, 8'd50, 1'b1, 16'hE79E, 1'b1, 2'd1}, // R5 select
    {4'd6, 1'b1, 8'd49, 1'b1, 16'hE79E, 1'b0, 2'd0}, // R6 short run
    {4'd7, 1'b1, 8'd60, 1'b1, 16'h679E, 1'b0, 2'd1}, // R7 last bit wrong
    {4'd7, 1'b0, 8'd50, 1'b1, 16'hE79E, 1'b1, 2'd1}, // R7 recovery
    {4'd8, 1'b0, 8'd55, 1'b1, 16'h0000, 1'b1, 2'd1}, // R8 R4 stays, pulses
    {4'd7, 1'b1, 8'd50, 1'b1, 16'hFFFE, 1'b0, 2'd1}, // R7 0 then 15 ones
    {4'd3, 1'b0, 8'd35, 1'b0, 16'h0000, 1'b0, 2'd1}, // R3 15+35 = 50
    {4'd5, 1'b0, 8'd0,  1'b1, 16'hE79E, 1'b1, 2'd0}, // R5 run spans window
    {4'd7, 1'b1, 8'd50, 1'b1, 16'hE79C, 1'b0, 2'd1}, // R7 bit 1 wrong
    {4'd3, 1'b1, 8'd49, 1'b1, 16'h0000, 1'b0, 2'd0}, // R3 zeros break run
    {4'd3, 1'b0, 8'd50, 1'b0, 16'h0000, 1'b0, 2'd1}  // R3 fresh 50
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbg_line_i = 1'b0;
  logic swd_sel_o;
  logic line_rst_o;

  int n_chk  = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done   = 1'b0;

  dbg_proto_watch i_dbg_proto_watch (
    .clk        (clk),
    .rst        (rst),
    .dbg_line_i (dbg_line_i),
    .swd_sel_o  (swd_sel_o),
    .line_rst_o (line_rst_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    dbg_line_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    dbg_line_i = b;
    @(negedge clk);
    if (line_rst_o) pulses++;
  endtask

  initial begin
    int pos;
    @(negedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 mode in reset", swd_sel_o, 0);
    check("R1 pulse in reset", line_rst_o, 0);
    rst = 1'b0;
    send_bit(1'b1);
    check("R1 mode after reset", swd_sel_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v][28]) apply_reset();
      pulses = 0;
      for (int k = 0; k < int'(VECS[v][27:20]); k++) send_bit(1'b1);
      if (VECS[v][19]) begin
        for (int k = 0; k < 16; k++) send_bit(VECS[v][3 + k]);
      end
      n_chk++;
      if (swd_sel_o != VECS[v][2]) begin
        n_fail++;
        $display("FAIL vector %0d R%0d mode: actual %0d expected %0d",
                 v, VECS[v][32:29], swd_sel_o, VECS[v][2]);
      end
      n_chk++;
      if (pulses != int'(VECS[v][1:0])) begin
        n_fail++;
        $display("FAIL vector %0d R%0d pulses: actual %0d expected %0d",
                 v, VECS[v][32:29], pulses, VECS[v][1:0]);
      end
    end

    // R2: exact position and width of the pulse
    apply_reset();
    pos = 0;
    for (int k = 1; k <= 60; k++) begin
      dbg_line_i = 1'b1;
      @(negedge clk);
      if (line_rst_o && pos == 0) pos = k;
    end
    check("R2 pulse after 50th one", pos, 50);

    // R9: reset in the middle of a stream while in serial-wire mode
    apply_reset();
    for (int k = 0; k < 50; k++) send_bit(1'b1);
    for (int k = 0; k < 16; k++) send_bit(1'(16'hE79E >> k));
    check("R9 selected before reset", swd_sel_o, 1);
    for (int k = 0; k < 30; k++) send_bit(1'b1);
    rst = 1'b1;
    dbg_line_i = 1'b1;
    @(negedge clk);
    check("R9 mode cleared by reset", swd_sel_o, 0);
    rst = 1'b0;
    pulses = 0;
    for (int k = 0; k < 49; k++) send_bit(1'b1);
    check("R9 run count cleared", pulses, 0);
    send_bit(1'b1);
    check("R2 pulse on fresh 50th one", pulses, 1);
    check("R1 mode JTAG after reset", swd_sel_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule